// File: doc/BRIEF.md
# Dual Alarm Comparator and Multi-Function Pin Driver

This block sits beside a real-time clock's time counters. It compares the live time of day against two independent alarm settings and drives one multi-function output pin. Each alarm has a 3-bit match mode. It raises its own interrupt flag the first time its comparison becomes true, and only software clears that flag. The pin shows one of three things: a divided square wave taken from the 32.768 kHz oscillator, the alarm state with a programmable polarity, or a plain static level taken from the control byte.

The oscillator enters as a level already synchronised to the system clock. A rising edge of that level is one oscillator tick. The square-wave generator responds to the signed calibration byte. In the 64 Hz setting every period is trimmed. In the 1 Hz setting only one period per trim interval is trimmed. When the battery-mode flag is high, only the alarm function of the pin keeps working. The time counters and the serial bus that loads the settings are outside this block. All settings arrive here as plain levels.

Top module: `rtc_alarm_mfp`

## Requirements
- R1: While `rst_n` is low, `alm_flag` is 00 and `mfp` is 1 (released).
- R2: With `ctrl[6]`=0, `ctrl[5:4]`=00 and `on_battery`=0, `mfp` equals `ctrl[7]` one clock later.
- R3: The `a_mode` codes compare one field each: 000 seconds, 001 minutes, 010 the 6-bit hour field (bit 5 is AM/PM in 12-hour format and a tens bit in 24-hour format), 100 date. A flag sets on an oscillator tick where that field equals the alarm's field.
- R4: Mode 011 matches when the weekday equals the alarm weekday and the time is midnight. Midnight is seconds 00, minutes 00, and hour 6'h00 when `t_h12`=0 or hour 6'h12 (12 AM) when `t_h12`=1.
- R5: Mode 111 requires seconds, minutes, hour, weekday, date and month all to match. Modes 101 and 110 never match.
- R6: Alarm n sets its flag only while its enable bit `ctrl[4+n]` is 1. A set flag stays set until a one-clock pulse on `flag_clr[n]` clears it. Enabling an alarm whose comparison already holds sets the flag on the next tick.
- R7: A flag sets only on the tick at which the comparison becomes true. Clearing it while the comparison still holds does not set it again. A new set needs the comparison to go false and then true.
- R8: When the square wave is off and `ctrl[5:4]` is not 00, `mfp` equals `a_pol` while any enabled alarm has its flag set, and the inverse of `a_pol` otherwise. Both alarms share that polarity and are ORed.
- R9: With `ctrl[6]`=1, rate `ctrl[2:0]` 001 gives a period of 8 ticks, 010 gives 4 ticks, and 011 gives the oscillator itself (1 tick).
- R10: Rates 1xx give 64 Hz with each period 2*(256+2*C) ticks when `cal[7]`=0, or 2*(256-2*C) ticks when `cal[7]`=1, where C=`cal[6:0]`.
- R11: Rate 000 gives periods of 2*`H1_HALF` ticks. Every `TRIM_EVERY`-th period, counted from the enable, is lengthened by 2*C ticks (`cal[7]`=0) or shortened by 2*C ticks (`cal[7]`=1).
- R12: With `on_battery`=1 the square wave is suppressed. Alarm flags and the alarm level still work. With no alarm enabled, `mfp` is 1.
- R13: The square wave (enabled and not on battery) takes priority over the alarm level on `mfp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_lvl | input | 1 | Synchronised 32.768 kHz oscillator level |
| ctrl | input | 8 | Control: [7] static level, [6] square-wave enable, [5:4] alarm enables, [2:0] rate |
| cal | input | 8 | Calibration: [7] 1 = subtract, [6:0] magnitude |
| on_battery | input | 1 | Running from the backup supply |
| t_h12 | input | 1 | Live hour format, 1 = 12-hour |
| t_sec | input | 7 | Live seconds, BCD |
| t_min | input | 7 | Live minutes, BCD |
| t_hour | input | 6 | Live hour field, BCD with AM/PM in 12-hour format |
| t_wday | input | 3 | Live weekday 1..7 |
| t_date | input | 6 | Live date, BCD |
| t_mon | input | 5 | Live month, BCD |
| a_sec | input | 2x7 | Alarm seconds per alarm |
| a_min | input | 2x7 | Alarm minutes per alarm |
| a_hour | input | 2x6 | Alarm hour field per alarm |
| a_wday | input | 2x3 | Alarm weekday per alarm |
| a_date | input | 2x6 | Alarm date per alarm |
| a_mon | input | 2x5 | Alarm month per alarm |
| a_mode | input | 2x3 | Match mode per alarm |
| a_pol | input | 1 | Pin level for an asserted alarm |
| flag_clr | input | 2 | Software clear pulse per flag |
| alm_flag | output | 2 | Alarm interrupt flags |
| mfp | output | 1 | Multi-function pin level |

## Verification
The bench aims at the places where a match detector usually goes wrong. Midnight in 12-hour format is hour 12 AM, so a design that compares against zero would miss it. Reserved modes must never fire, and a design that maps them to a real mode would raise a flag. A flag cleared while its match still holds must stay clear, and a level-sensitive design would raise it again at once. The scoreboard measures square-wave periods edge to edge, covering the trimmed 64 Hz periods in both signs and the one trimmed 1 Hz period per interval. A divider that trimmed every period, trimmed the wrong one, or ignored the sign would show up as a period mismatch. Battery mode and the output priority are checked by watching whether the pin toggles over a window.

// File: rtl/mfp_alarm_pkg.sv
package mfp_alarm_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 3;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int MODE_W = 3;
  localparam int N_ALM  = 2;

  // control byte bit positions
  localparam int CTL_OUT  = 7;
  localparam int CTL_SQWE = 6;
  localparam int CTL_EN0  = 4;

  localparam logic [HOUR_W-1:0] HOUR_MIDNIGHT_24 = 6'h00;
  localparam logic [HOUR_W-1:0] HOUR_MIDNIGHT_12 = 6'h12;

  typedef enum logic [MODE_W-1:0] {
    MATCH_SEC  = 3'b000,
    MATCH_MIN  = 3'b001,
    MATCH_HOUR = 3'b010,
    MATCH_WDAY = 3'b011,
    MATCH_DATE = 3'b100,
    MATCH_RSV5 = 3'b101,
    MATCH_RSV6 = 3'b110,
    MATCH_ALL  = 3'b111
  } match_mode_e;

  typedef enum logic [2:0] {
    RATE_1HZ = 3'b000,
    RATE_4K  = 3'b001,
    RATE_8K  = 3'b010,
    RATE_32K = 3'b011,
    RATE_64  = 3'b100
  } rate_e;

  typedef struct packed {
    logic [MON_W-1:0]  mon;
    logic [DATE_W-1:0] date;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tod_t;
endpackage

// File: rtl/mfp_alarm_cmp.sv
module mfp_alarm_cmp
  import mfp_alarm_pkg::*;
(
  input  tod_t        live,
  input  tod_t        ref_t,
  input  logic        h12,
  input  match_mode_e mode,
  output logic        hit
);
  logic midnight;
  logic hour_zero;

  always_comb begin
    hour_zero = h12 ? (live.hour == HOUR_MIDNIGHT_12) : (live.hour == HOUR_MIDNIGHT_24);
    midnight  = hour_zero && (live.min == '0) && (live.sec == '0);
  end

  always_comb begin
    unique case (mode)
      MATCH_SEC:  hit = (live.sec == ref_t.sec);
      MATCH_MIN:  hit = (live.min == ref_t.min);
      MATCH_HOUR: hit = (live.hour == ref_t.hour);
      MATCH_WDAY: hit = (live.wday == ref_t.wday) && midnight;
      MATCH_DATE: hit = (live.date == ref_t.date);
      MATCH_ALL:  hit = (live == ref_t);
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mfp_alarm_flag.sv
module mfp_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic hit_q;
  logic set_now;

  assign set_now = tick && en && hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (tick) hit_q <= hit && en;
      if (set_now)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mfp_sq_gen.sv
module mfp_sq_gen
  import mfp_alarm_pkg::*;
#(
  parameter int H1_HALF    = 16384,
  parameter int TRIM_EVERY = 60,
  parameter int S64_HALF   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       osc_q,
  input  logic       run,
  input  logic [2:0] rate,
  input  logic [7:0] cal,
  output logic       sq
);
  localparam int MAXH  = (H1_HALF > S64_HALF) ? H1_HALF : S64_HALF;
  localparam int CNT_W = $clog2(MAXH + 256) + 1;
  localparam int CYC_W = $clog2(TRIM_EVERY) + 1;
  localparam int HALF_4K = 4;
  localparam int HALF_8K = 2;

  rate_e            rsel;
  logic [3:0]       cfg, cfg_q;
  logic [CNT_W-1:0] cnt, base, mag, adj;
  logic [CYC_W-1:0] cyc;
  logic             sq_hi, trim_now, restart;

  always_comb begin
    rsel = rate[2] ? RATE_64 : rate_e'(rate);
    cfg  = {run, rsel};
    restart = !run || (cfg != cfg_q);
    unique case (rsel)
      RATE_1HZ: base = CNT_W'(H1_HALF);
      RATE_4K:  base = CNT_W'(HALF_4K);
      RATE_8K:  base = CNT_W'(HALF_8K);
      default:  base = CNT_W'(S64_HALF);
    endcase
    mag = CNT_W'({cal[6:0], 1'b0});
    trim_now = (rsel == RATE_64) ||
               ((rsel == RATE_1HZ) && !sq_hi && (cyc == CYC_W'(TRIM_EVERY - 1)));
    if (!trim_now)     adj = base;
    else if (!cal[7])  adj = base + mag;
    else if (base > mag) adj = base - mag;
    else               adj = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt   <= '0;
      cyc   <= '0;
      sq_hi <= 1'b1;
    end else begin
      cfg_q <= cfg;
      if (restart) begin
        cnt   <= '0;
        cyc   <= '0;
        sq_hi <= 1'b1;
      end else if (tick) begin
        if (cnt + 1'b1 >= adj) begin
          cnt   <= '0;
          sq_hi <= !sq_hi;
          if (!sq_hi) cyc <= (cyc == CYC_W'(TRIM_EVERY - 1)) ? '0 : cyc + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sq = (rsel == RATE_32K) ? osc_q : sq_hi;
endmodule

// File: rtl/mfp_pin_mux.sv
module mfp_pin_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_run,
  input  logic sq,
  input  logic alm_any_en,
  input  logic alm_active,
  input  logic pol,
  input  logic on_battery,
  input  logic out_bit,
  output logic mfp
);
  logic nxt;

  always_comb begin
    if (sq_run)          nxt = sq;
    else if (alm_any_en) nxt = alm_active ? pol : !pol;
    else if (on_battery) nxt = 1'b1;
    else                 nxt = out_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mfp <= 1'b1;
    else        mfp <= nxt;
  end
endmodule

// File: rtl/rtc_alarm_mfp.sv
module rtc_alarm_mfp
  import mfp_alarm_pkg::*;
#(
  parameter int H1_HALF    = 16384,
  parameter int TRIM_EVERY = 60,
  parameter int S64_HALF   = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xtal_lvl,
  input  logic [7:0]                   ctrl,
  input  logic [7:0]                   cal,
  input  logic                         on_battery,
  input  logic                         t_h12,
  input  logic [SEC_W-1:0]             t_sec,
  input  logic [MIN_W-1:0]             t_min,
  input  logic [HOUR_W-1:0]            t_hour,
  input  logic [WDAY_W-1:0]            t_wday,
  input  logic [DATE_W-1:0]            t_date,
  input  logic [MON_W-1:0]             t_mon,
  input  logic [N_ALM-1:0][SEC_W-1:0]  a_sec,
  input  logic [N_ALM-1:0][MIN_W-1:0]  a_min,
  input  logic [N_ALM-1:0][HOUR_W-1:0] a_hour,
  input  logic [N_ALM-1:0][WDAY_W-1:0] a_wday,
  input  logic [N_ALM-1:0][DATE_W-1:0] a_date,
  input  logic [N_ALM-1:0][MON_W-1:0]  a_mon,
  input  logic [N_ALM-1:0][MODE_W-1:0] a_mode,
  input  logic                         a_pol,
  input  logic [N_ALM-1:0]             flag_clr,
  output logic [N_ALM-1:0]             alm_flag,
  output logic                         mfp
);
  logic             osc_q, tick, sq, sq_run;
  logic [N_ALM-1:0] en, hit;
  tod_t             live;
  logic             unused_ctl;

  assign unused_ctl = ctrl[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_q <= 1'b0;
    else        osc_q <= xtal_lvl;
  end
  assign tick = xtal_lvl && !osc_q;

  always_comb begin
    live.sec  = t_sec;
    live.min  = t_min;
    live.hour = t_hour;
    live.wday = t_wday;
    live.date = t_date;
    live.mon  = t_mon;
  end

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    tod_t ref_t;
    always_comb begin
      ref_t.sec  = a_sec[i];
      ref_t.min  = a_min[i];
      ref_t.hour = a_hour[i];
      ref_t.wday = a_wday[i];
      ref_t.date = a_date[i];
      ref_t.mon  = a_mon[i];
    end
    assign en[i] = ctrl[CTL_EN0 + i];

    mfp_alarm_cmp u_cmp (
      .live (live),
      .ref_t(ref_t),
      .h12  (t_h12),
      .mode (match_mode_e'(a_mode[i])),
      .hit  (hit[i])
    );

    mfp_alarm_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .en   (en[i]),
      .hit  (hit[i]),
      .clr  (flag_clr[i]),
      .flag (alm_flag[i])
    );
  end

  assign sq_run = ctrl[CTL_SQWE] && !on_battery;

  mfp_sq_gen #(
    .H1_HALF   (H1_HALF),
    .TRIM_EVERY(TRIM_EVERY),
    .S64_HALF  (S64_HALF)
  ) u_sq (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .osc_q(osc_q),
    .run  (sq_run),
    .rate (ctrl[2:0]),
    .cal  (cal),
    .sq   (sq)
  );

  mfp_pin_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .sq_run    (sq_run),
    .sq        (sq),
    .alm_any_en(|en),
    .alm_active(|(en & alm_flag)),
    .pol       (a_pol),
    .on_battery(on_battery),
    .out_bit   (ctrl[CTL_OUT]),
    .mfp       (mfp)
  );
endmodule

// File: rtl/rtc_alarm_mfp_chk.sv
module rtc_alarm_mfp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic       on_battery,
  input logic       a_pol,
  input logic [1:0] flag_clr,
  input logic [1:0] alm_flag,
  input logic       mfp
);
  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[6] && ctrl[5:4] == 2'b00 && !on_battery) |=> (mfp == $past(ctrl[7]))); // R2

  AST_BATT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && ctrl[5:4] == 2'b00) |=> mfp); // R12

  AST_ALARM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl[6] && !on_battery) && ctrl[5:4] == 2'b01)
      |=> (mfp == ($past(alm_flag[0]) ? $past(a_pol) : !$past(a_pol)))); // R8

  AST_FLAG0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag[0]) |-> $past(ctrl[4])); // R6

  AST_FLAG1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag[1]) |-> $past(ctrl[5])); // R6

  AST_FLAG0_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_flag[0]) |-> $past(flag_clr[0])); // R6

  AST_FLAG1_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_flag[1]) |-> $past(flag_clr[1])); // R6
endmodule

bind rtc_alarm_mfp rtc_alarm_mfp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl      (ctrl),
  .on_battery(on_battery),
  .a_pol     (a_pol),
  .flag_clr  (flag_clr),
  .alm_flag  (alm_flag),
  .mfp       (mfp)
);

// File: tb/tb_rtc_alarm_mfp.sv
module tb_rtc_alarm_mfp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_lvl = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [7:0] cal = 8'h00;
  logic on_battery = 1'b0;
  logic t_h12 = 1'b0;
  logic [6:0] t_sec = 7'h01, t_min = 7'h02;
  logic [5:0] t_hour = 6'h03, t_date = 6'h04;
  logic [2:0] t_wday = 3'd1;
  logic [4:0] t_mon = 5'h05;
  logic [1:0][6:0] a_sec, a_min;
  logic [1:0][5:0] a_hour, a_date;
  logic [1:0][2:0] a_wday, a_mode;
  logic [1:0][4:0] a_mon;
  logic a_pol = 1'b1;
  logic [1:0] flag_clr = 2'b00;
  logic [1:0] alm_flag;
  logic mfp;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  int exp_q[$];
  string mon_req = "R9";
  bit armed = 1'b0;

  rtc_alarm_mfp #(.H1_HALF(64), .TRIM_EVERY(3)) dut (
    .clk(clk), .rst_n(rst_n), .xtal_lvl(xtal_lvl), .ctrl(ctrl), .cal(cal),
    .on_battery(on_battery), .t_h12(t_h12), .t_sec(t_sec), .t_min(t_min),
    .t_hour(t_hour), .t_wday(t_wday), .t_date(t_date), .t_mon(t_mon),
    .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour), .a_wday(a_wday),
    .a_date(a_date), .a_mon(a_mon), .a_mode(a_mode), .a_pol(a_pol),
    .flag_clr(flag_clr), .alm_flag(alm_flag), .mfp(mfp)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc_cnt++;

  // oscillator: one tick every 4 clocks
  initial forever begin
    repeat (2) @(negedge clk);
    xtal_lvl = ~xtal_lvl;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic neutral();
    t_h12 = 1'b0; t_sec = 7'h01; t_min = 7'h02; t_hour = 6'h03;
    t_wday = 3'd1; t_date = 6'h04; t_mon = 5'h05;
    settle();
  endtask

  task automatic clr(input int idx);
    flag_clr[idx] = 1'b1;
    @(negedge clk);
    flag_clr[idx] = 1'b0;
    settle();
  endtask

  // scoreboard monitor: skip first interval, then compare periods
  int rises = 0, t_start = 0;
  bit mfp_prev = 1'b0;
  always @(negedge clk) begin
    if (armed) begin
      if (mfp && !mfp_prev) begin
        rises++;
        if (rises == 2) t_start = cyc_cnt;
        else if (rises > 2 && exp_q.size() != 0) begin
          int e, got;
          e = exp_q.pop_front();
          got = cyc_cnt - t_start;
          t_start = cyc_cnt;
          chk(got == e, mon_req, got, e);
        end
      end
    end else rises = 0;
    mfp_prev = mfp;
  end

  task automatic sq_run(input logic [7:0] c, input logic [7:0] k, input string req,
                        input int p0, input int p1, input int p2, input int p3, input int n);
    ctrl = 8'h00; cal = k; settle();
    mon_req = req;
    if (n > 0) exp_q.push_back(p0);
    if (n > 1) exp_q.push_back(p1);
    if (n > 2) exp_q.push_back(p2);
    if (n > 3) exp_q.push_back(p3);
    armed = 1'b1;
    ctrl = c;
    while (exp_q.size() != 0) @(negedge clk);
    armed = 1'b0;
    ctrl = 8'h00;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int zeros, ones;
    for (int i = 0; i < 2; i++) begin
      a_sec[i] = 7'h30; a_min[i] = 7'h15; a_hour[i] = 6'h09;
      a_wday[i] = 3'd3; a_date[i] = 6'h14; a_mon[i] = 5'h06; a_mode[i] = 3'b101;
    end
    repeat (5) @(negedge clk);
    chk(mfp == 1'b1, "R1 mfp", mfp, 1);
    chk(alm_flag == 2'b00, "R1 flags", alm_flag, 0);
    rst_n = 1'b1;
    settle();

    // R2 static level
    ctrl = 8'h80; settle();
    chk(mfp == 1'b1, "R2 high", mfp, 1);
    ctrl = 8'h00; settle();
    chk(mfp == 1'b0, "R2 low", mfp, 0);

    // R3 seconds, alarm 0 enabled, pol 1
    ctrl = 8'h10; a_mode[0] = 3'b000; neutral();
    chk(alm_flag[0] == 1'b0, "R3 no match", alm_flag[0], 0);
    chk(mfp == 1'b0, "R8 idle inverse", mfp, 0);
    t_sec = 7'h30; settle();
    chk(alm_flag[0] == 1'b1, "R3 sec", alm_flag[0], 1);
    chk(mfp == 1'b1, "R8 asserted", mfp, 1);
    clr(0);
    chk(alm_flag[0] == 1'b0, "R7 no re-raise", alm_flag[0], 0);
    chk(mfp == 1'b0, "R8 after clear", mfp, 0);
    t_sec = 7'h31; settle();
    t_sec = 7'h30; settle();
    chk(alm_flag[0] == 1'b1, "R7 re-raise", alm_flag[0], 1);
    clr(0);

    a_mode[0] = 3'b001; neutral();
    t_min = 7'h15; settle();
    chk(alm_flag[0] == 1'b1, "R3 min", alm_flag[0], 1);
    clr(0);
    a_mode[0] = 3'b010; neutral();
    t_hour = 6'h09; settle();
    chk(alm_flag[0] == 1'b1, "R3 hour", alm_flag[0], 1);
    clr(0);
    a_mode[0] = 3'b100; neutral();
    t_date = 6'h14; settle();
    chk(alm_flag[0] == 1'b1, "R3 date", alm_flag[0], 1);
    clr(0);

    // R4 weekday at midnight
    a_mode[0] = 3'b011; neutral();
    t_wday = 3'd3; t_hour = 6'h09; settle();
    chk(alm_flag[0] == 1'b0, "R4 not midnight", alm_flag[0], 0);
    t_hour = 6'h00; t_min = 7'h00; t_sec = 7'h00; settle();
    chk(alm_flag[0] == 1'b1, "R4 midnight 24h", alm_flag[0], 1);
    clr(0);
    neutral();
    t_h12 = 1'b1; t_wday = 3'd3; t_hour = 6'h00; t_min = 7'h00; t_sec = 7'h00; settle();
    chk(alm_flag[0] == 1'b0, "R4 12h hour zero", alm_flag[0], 0);
    t_hour = 6'h12; settle();
    chk(alm_flag[0] == 1'b1, "R4 midnight 12h", alm_flag[0], 1);
    clr(0);

    // R5 full match and reserved codes
    a_mode[0] = 3'b111; neutral();
    t_sec = 7'h30; t_min = 7'h15; t_hour = 6'h09; t_wday = 3'd3; t_date = 6'h14; settle();
    chk(alm_flag[0] == 1'b0, "R5 month differs", alm_flag[0], 0);
    t_mon = 5'h06; settle();
    chk(alm_flag[0] == 1'b1, "R5 all", alm_flag[0], 1);
    clr(0);
    a_mode[0] = 3'b101; neutral();
    t_sec = 7'h30; t_min = 7'h15; t_hour = 6'h09; t_wday = 3'd3; t_date = 6'h14; t_mon = 5'h06; settle();
    chk(alm_flag[0] == 1'b0, "R5 reserved 101", alm_flag[0], 0);
    a_mode[0] = 3'b110; settle();
    chk(alm_flag[0] == 1'b0, "R5 reserved 110", alm_flag[0], 0);

    // R6 enable gating on alarm 1
    a_mode[0] = 3'b101; a_mode[1] = 3'b000; neutral();
    t_sec = 7'h30; settle();
    chk(alm_flag[1] == 1'b0, "R6 disabled", alm_flag[1], 0);
    ctrl = 8'h30; settle();
    chk(alm_flag[1] == 1'b1, "R6 enabled", alm_flag[1], 1);
    repeat (20) @(negedge clk);
    chk(alm_flag[1] == 1'b1, "R6 holds", alm_flag[1], 1);

    // R8 both enabled, ORed, pol 0
    a_pol = 1'b0; settle();
    chk(mfp == 1'b0, "R8 OR pol0", mfp, 0);
    clr(1);
    chk(mfp == 1'b1, "R8 idle pol0", mfp, 1);

    // R12 battery
    on_battery = 1'b1; ctrl = 8'h43; a_mode[0] = 3'b000; neutral();
    ones = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); if (mfp) ones++; end
    chk(ones == 24, "R12 released", ones, 24);
    ctrl = 8'h53; settle();
    t_sec = 7'h30; settle();
    chk(alm_flag[0] == 1'b1, "R12 alarm flag", alm_flag[0], 1);
    chk(mfp == 1'b0, "R12 alarm level", mfp, 0);

    // R13 priority: square wave over alarm
    on_battery = 1'b0; settle();
    zeros = 0; ones = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); if (mfp) ones++; else zeros++; end
    chk(ones > 0 && zeros > 0, "R13 toggles", ones, 12);
    clr(0);
    a_pol = 1'b1;

    // square-wave scoreboard (clock counts: 4 per tick)
    sq_run(8'h41, 8'h00, "R9 rate 001", 32, 32, 32, 32, 4);
    sq_run(8'h42, 8'h00, "R9 rate 010", 16, 16, 16, 16, 4);
    sq_run(8'h43, 8'h00, "R9 rate 011", 4, 4, 4, 4, 4);
    sq_run(8'h44, 8'h00, "R10 cal 0", 2048, 2048, 0, 0, 2);
    sq_run(8'h47, 8'h05, "R10 add", 2128, 2128, 0, 0, 2);
    sq_run(8'h44, 8'h85, "R10 subtract", 1968, 1968, 0, 0, 2);
    sq_run(8'h40, 8'h03, "R11 add", 512, 536, 512, 512, 4);
    sq_run(8'h40, 8'h83, "R11 subtract", 512, 488, 512, 512, 4);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule